// File: doc/BRIEF.md
# MII Frame Transmitter

This block turns a MAC-side byte stream into a complete Ethernet frame on a 4-bit media independent transmit channel. The source presents, in order, the destination address, the source address, the type/length and the payload, with a valid/ready handshake and a last-byte marker. The block adds the preamble and start delimiter. It can insert a VLAN tag after the source address. It zero-pads short frames, appends the frame check sequence and keeps the line quiet for an interframe gap before the next frame.

All logic runs from a fast system clock and advances only on cycles where a nibble-rate enable is high. The same design therefore serves the 25 MHz nibble rate of 100 Mb/s operation and the 2.5 MHz rate of 10 Mb/s operation. The outputs are registered and change only on enable cycles. A tag inserted by the block carries a 4-bit priority and a 12-bit VLAN identifier, which are sampled when the frame starts.

The line cannot be paused once a frame has begun. If the source has no byte ready when a stream byte slot comes up, the block sends a zero byte in that slot and marks both of its nibbles with the transmit error line, which corrupts the frame on purpose. The source's byte stays pending for the next stream slot.

Top module: `mii_frame_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, txd is 0, tx_en is 0 and tx_er is 0, and s_ready is 0.
- R2: txd, tx_en and tx_er change only on the clock edge that ends a cycle in which nib_en is high. Each such edge puts one nibble on the line.
- R3: A frame begins with fifteen nibbles of 0x5 followed by one nibble of 0xD. This is seven 0x55 bytes and one 0xD5 delimiter byte, each sent low nibble first.
- R4: Each byte after the delimiter is sent as two nibbles, bits [3:0] first and then bits [7:4]. The stream bytes appear in the order they were accepted.
- R5: When tag_en is high at frame start and the stream has more than 12 bytes, the block inserts four bytes after the 12th stream byte: 0x81, 0x00, {tag_prio, tag_vid[11:8]} and tag_vid[7:0]. It accepts no stream byte during these four byte slots.
- R6: If the bytes from the destination address through the last stream byte, including any tag, number fewer than 60, the block appends 0x00 bytes until there are exactly 60. Longer frames get no padding.
- R7: Four check bytes follow the last data or pad byte. They are the bitwise inverse of a CRC-32 over every byte from the destination address through the padding, computed with reflected polynomial 0xEDB88320 from an all-ones start value, and sent least significant byte first.
- R8: tx_en is high for exactly the nibbles from the first preamble nibble through the last check nibble. A frame therefore lasts 16 + 2*(body bytes) + 8 nibbles.
- R9: Between the end of one frame and the start of the next, tx_en stays low for at least 24 nibble times.
- R10: If s_valid is low when a stream byte slot comes up, the block sends 0x00 for that slot with tx_er high on both nibbles. It includes that byte in the check sequence and continues the frame. tx_er is never high outside a frame.
- R11: s_ready is high only in a cycle with nib_en high, and only at the start of a stream byte slot. A frame starts only when s_valid is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_en | input | 1 | Nibble-rate enable; one nibble per high cycle |
| s_valid | input | 1 | Stream byte available |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final stream byte of the frame |
| s_ready | output | 1 | Stream byte taken this cycle when s_valid is high |
| tag_en | input | 1 | Insert a VLAN tag into the frame being started |
| tag_prio | input | 4 | Priority field of the inserted tag |
| tag_vid | input | 12 | VLAN identifier of the inserted tag |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable |
| tx_er | output | 1 | Transmit error |

## Verification
Some rules are checked by assertions on every cycle: the outputs hold between enable cycles, tx_er only appears inside a frame, the gap before each new frame is long enough, no check byte goes out before the frame body reaches 60 bytes, the CRC register stays frozen while the check bytes are sent, and an accepted byte always moves on to its high nibble. The content of a frame can only be shown by the bench's scenarios, because a reference model rebuilds each expected frame. That covers the preamble pattern, nibble order, tag placement and fields, the padding length, the CRC value, and where the error-marked zero byte lands after an underrun. The scenarios mix three enable patterns with directed cases at the padding boundary, with and without a tag.

// File: rtl/mii_tx_pkg.sv
`timescale 1ns/1ps
package mii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_BODY,
    ST_PAD,
    ST_FCS,
    ST_IPG
  } tx_state_e;

  localparam logic [7:0]  PRE_BYTE  = 8'h55;
  localparam logic [7:0]  SFD_BYTE  = 8'hD5;
  localparam logic [15:0] VLAN_TPID = 16'h8100;
  localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;

  // One byte of the reflected CRC-32, bit 0 of the byte first.
  function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                             input logic [7:0]  data);
    logic [31:0] c;
    c = crc_in ^ {24'h0, data};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
    end
    return c;
  endfunction

  // Byte idx (0..3) of the inserted tag, in wire order.
  function automatic logic [7:0] tag_byte(input logic [1:0]  idx,
                                          input logic [3:0]  prio,
                                          input logic [11:0] vid);
    logic [7:0] b;
    case (idx)
      2'd0:    b = VLAN_TPID[15:8];
      2'd1:    b = VLAN_TPID[7:0];
      2'd2:    b = {prio, vid[11:8]};
      default: b = vid[7:0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/mii_tx_crc.sv
`timescale 1ns/1ps
module mii_tx_crc
  import mii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] crc_q,
  output logic [31:0] fcs
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (init) begin
      crc_q <= CRC_SEED;
    end else if (upd) begin
      crc_q <= crc32_step(crc_q, din);
    end
  end

  assign fcs = ~crc_q;

endmodule

// File: rtl/mii_tx_seq.sv
`timescale 1ns/1ps
module mii_tx_seq
  import mii_tx_pkg::*;
#(
  parameter int PRE_LEN  = 7,
  parameter int MIN_BODY = 60,
  parameter int TAG_POS  = 12,
  parameter int IPG_NIB  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nib_en,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  output logic        s_ready,
  input  logic        tag_en,
  input  logic [3:0]  tag_prio,
  input  logic [11:0] tag_vid,
  input  logic [31:0] fcs,
  output logic        crc_init,
  output logic        crc_upd,
  output logic [7:0]  crc_din,
  output logic        in_fcs,
  output logic        nx_en,
  output logic [3:0]  nx_dat,
  output logic        nx_err
);

  localparam int BCW = $clog2(MIN_BODY + 1);
  localparam int IGW = $clog2(IPG_NIB + 1);
  localparam int CW  = $clog2(PRE_LEN + 1);
  localparam logic [BCW-1:0] BODY_MAX = BCW'(MIN_BODY);
  localparam logic [BCW-1:0] BODY_M1  = BCW'(MIN_BODY - 1);
  localparam logic [BCW-1:0] TAG_LO   = BCW'(TAG_POS);
  localparam logic [BCW-1:0] TAG_HI   = BCW'(TAG_POS + 4);
  localparam logic [CW-1:0]  PRE_END  = CW'(PRE_LEN - 1);
  localparam logic [CW-1:0]  FCS_END  = CW'(3);
  localparam logic [IGW-1:0] IPG_END  = IGW'(IPG_NIB - 1);

  tx_state_e      state_q;
  logic           phase_q;
  logic [CW-1:0]  cnt_q;
  logic [BCW-1:0] body_q;
  logic [IGW-1:0] gap_q;
  logic [7:0]     cur_byte_q;
  logic           cur_err_q;
  logic           last_q;
  logic           tag_on_q;
  logic [3:0]     tag_prio_q;
  logic [11:0]    tag_vid_q;

  // Internal events, named for the assertions.
  logic       tag_slot;
  logic       body_done;
  logic       active;
  logic [7:0] slot_byte;
  logic       slot_err;

  assign tag_slot  = (state_q == ST_BODY) && tag_on_q &&
                     (body_q >= TAG_LO) && (body_q < TAG_HI);
  assign body_done = (body_q >= BODY_M1);
  assign active    = (state_q != ST_IDLE) && (state_q != ST_IPG);
  assign s_ready   = nib_en && (state_q == ST_BODY) && !phase_q && !tag_slot;
  assign slot_err  = (state_q == ST_BODY) && !tag_slot && !s_valid;
  assign in_fcs    = (state_q == ST_FCS);

  always_comb begin
    unique case (state_q)
      ST_PRE:  slot_byte = PRE_BYTE;
      ST_SFD:  slot_byte = SFD_BYTE;
      ST_BODY: begin
        if (tag_slot)     slot_byte = tag_byte(2'(body_q - TAG_LO), tag_prio_q, tag_vid_q);
        else if (s_valid) slot_byte = s_data;
        else              slot_byte = 8'h00;
      end
      ST_FCS:  slot_byte = fcs[{cnt_q[1:0], 3'b000} +: 8];
      default: slot_byte = 8'h00;
    endcase
  end

  always_comb begin
    nx_en  = active;
    nx_dat = 4'h0;
    nx_err = 1'b0;
    if (active) begin
      nx_dat = phase_q ? cur_byte_q[7:4] : slot_byte[3:0];
      nx_err = phase_q ? cur_err_q : slot_err;
    end
  end

  assign crc_init = nib_en && (state_q == ST_IDLE) && s_valid;
  assign crc_upd  = nib_en && phase_q &&
                    ((state_q == ST_BODY) || (state_q == ST_PAD));
  assign crc_din  = cur_byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      phase_q    <= 1'b0;
      cnt_q      <= '0;
      body_q     <= '0;
      gap_q      <= '0;
      cur_byte_q <= 8'h00;
      cur_err_q  <= 1'b0;
      last_q     <= 1'b0;
      tag_on_q   <= 1'b0;
      tag_prio_q <= 4'h0;
      tag_vid_q  <= 12'h000;
    end else if (nib_en) begin
      unique case (state_q)
        ST_IDLE: begin
          if (s_valid) begin
            state_q    <= ST_PRE;
            cnt_q      <= '0;
            phase_q    <= 1'b0;
            tag_on_q   <= tag_en;
            tag_prio_q <= tag_prio;
            tag_vid_q  <= tag_vid;
          end
        end
        ST_IPG: begin
          if (gap_q == IPG_END) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: begin
          if (!phase_q) begin
            phase_q    <= 1'b1;
            cur_byte_q <= slot_byte;
            cur_err_q  <= slot_err;
            if (s_ready && s_valid && s_last) last_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            unique case (state_q)
              ST_PRE: begin
                if (cnt_q == PRE_END) state_q <= ST_SFD;
                else                  cnt_q   <= cnt_q + 1'b1;
              end
              ST_SFD: begin
                state_q <= ST_BODY;
                body_q  <= '0;
                last_q  <= 1'b0;
              end
              ST_BODY: begin
                if (body_q != BODY_MAX) body_q <= body_q + 1'b1;
                if (last_q) begin
                  state_q <= body_done ? ST_FCS : ST_PAD;
                  cnt_q   <= '0;
                end
              end
              ST_PAD: begin
                if (body_q != BODY_MAX) body_q <= body_q + 1'b1;
                if (body_done) begin
                  state_q <= ST_FCS;
                  cnt_q   <= '0;
                end
              end
              ST_FCS: begin
                if (cnt_q == FCS_END) begin
                  state_q <= ST_IPG;
                  gap_q   <= '0;
                end else begin
                  cnt_q <= cnt_q + 1'b1;
                end
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  AST_ACCEPT_THEN_HIGH_NIB: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid) |=> phase_q) else $error("accepted byte skipped its high nibble"); // R11

  AST_FCS_AFTER_MIN_BODY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FCS) |-> (body_q == BODY_MAX)) else $error("check bytes before minimum body"); // R6

endmodule

// File: rtl/mii_tx_nib.sv
`timescale 1ns/1ps
module mii_tx_nib #(
  parameter int IPG_NIB = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nib_en,
  input  logic       nx_en,
  input  logic [3:0] nx_dat,
  input  logic       nx_err,
  output logic [3:0] txd,
  output logic       tx_en,
  output logic       tx_er
);

  localparam int IGW = $clog2(IPG_NIB + 1);
  localparam logic [IGW-1:0] GAP_MAX = IGW'(IPG_NIB);

  logic [IGW-1:0] idle_cnt_q;
  logic           frame_start;

  assign frame_start = nib_en && nx_en && !tx_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd        <= 4'h0;
      tx_en      <= 1'b0;
      tx_er      <= 1'b0;
      idle_cnt_q <= GAP_MAX;
    end else if (nib_en) begin
      txd   <= nx_dat;
      tx_en <= nx_en;
      tx_er <= nx_err;
      if (tx_en)                    idle_cnt_q <= '0;
      else if (idle_cnt_q != GAP_MAX) idle_cnt_q <= idle_cnt_q + 1'b1;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_en |=> $stable({txd, tx_en, tx_er})) else $error("line changed without enable"); // R2

  AST_ERR_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_er |-> tx_en) else $error("error marked outside frame"); // R10

  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (idle_cnt_q == GAP_MAX)) else $error("interframe gap too short"); // R9

endmodule

// File: rtl/mii_frame_tx.sv
`timescale 1ns/1ps
module mii_frame_tx #(
  parameter int PRE_LEN  = 7,
  parameter int MIN_BODY = 60,
  parameter int TAG_POS  = 12,
  parameter int IPG_NIB  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nib_en,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  output logic        s_ready,
  input  logic        tag_en,
  input  logic [3:0]  tag_prio,
  input  logic [11:0] tag_vid,
  output logic [3:0]  txd,
  output logic        tx_en,
  output logic        tx_er
);

  logic        crc_init;
  logic        crc_upd;
  logic [7:0]  crc_din;
  logic [31:0] crc_q;
  logic [31:0] fcs;
  logic        in_fcs;
  logic        nx_en;
  logic [3:0]  nx_dat;
  logic        nx_err;

  mii_tx_seq #(
    .PRE_LEN (PRE_LEN),
    .MIN_BODY(MIN_BODY),
    .TAG_POS (TAG_POS),
    .IPG_NIB (IPG_NIB)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .nib_en  (nib_en),
    .s_valid (s_valid),
    .s_data  (s_data),
    .s_last  (s_last),
    .s_ready (s_ready),
    .tag_en  (tag_en),
    .tag_prio(tag_prio),
    .tag_vid (tag_vid),
    .fcs     (fcs),
    .crc_init(crc_init),
    .crc_upd (crc_upd),
    .crc_din (crc_din),
    .in_fcs  (in_fcs),
    .nx_en   (nx_en),
    .nx_dat  (nx_dat),
    .nx_err  (nx_err)
  );

  mii_tx_crc crc_i (
    .clk  (clk),
    .rst_n(rst_n),
    .init (crc_init),
    .upd  (crc_upd),
    .din  (crc_din),
    .crc_q(crc_q),
    .fcs  (fcs)
  );

  mii_tx_nib #(
    .IPG_NIB(IPG_NIB)
  ) nib_i (
    .clk   (clk),
    .rst_n (rst_n),
    .nib_en(nib_en),
    .nx_en (nx_en),
    .nx_dat(nx_dat),
    .nx_err(nx_err),
    .txd   (txd),
    .tx_en (tx_en),
    .tx_er (tx_er)
  );

  AST_CRC_FROZEN_IN_FCS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fcs && $past(in_fcs)) |-> $stable(crc_q)) else $error("CRC moved while sending check bytes"); // R7

endmodule

// File: tb/mii_frame_tx_tb_top.sv
`timescale 1ns/1ps
module mii_frame_tx_tb_top;

  localparam int NF   = 14;
  localparam int MAXP = 160;
  localparam int MAXN = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nib_en;
  logic        s_valid;
  logic [7:0]  s_data;
  logic        s_last;
  logic        s_ready;
  logic        tag_en;
  logic [3:0]  tag_prio;
  logic [11:0] tag_vid;
  logic [3:0]  txd;
  logic        tx_en;
  logic        tx_er;

  always #2.5 clk = ~clk;

  mii_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .nib_en(nib_en),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .tag_en(tag_en), .tag_prio(tag_prio), .tag_vid(tag_vid),
    .txd(txd), .tx_en(tx_en), .tx_er(tx_er)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0]  pay [NF][MAXP];
  int          plen [NF];
  bit          ftag [NF];
  logic [3:0]  fprio [NF];
  logic [11:0] fvid [NF];
  int          furun [NF];

  logic [3:0] cap_nib [MAXN];
  bit         cap_er  [MAXN];
  int         cap_len;
  logic [3:0] exp_nib [MAXN];
  bit         exp_er  [MAXN];
  int         exp_len;
  logic [7:0] eb [MAXP + 8];
  int         ebl, e_pad_at, e_tag_at;

  // Source and monitor state
  int  cur_k, ptr, mon_k, gap, cyc, starts, hold_bad, rdy_bad;
  bit  skipped, src_active, acc_prev, tick_prev, in_frm, tgl;
  logic [5:0] last_out;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c;
    bit fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ eb[i][b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return c;
  endfunction

  task automatic build_exp(int k);
    int j, err_at;
    bit used;
    logic [31:0] f;
    ebl = 0; j = 0; used = 0; e_tag_at = -1; err_at = -1;
    while (j < plen[k]) begin
      if (ftag[k] && ebl == 12 && e_tag_at < 0) begin
        e_tag_at = 12;
        eb[ebl] = 8'h81; eb[ebl+1] = 8'h00;
        eb[ebl+2] = {fprio[k], fvid[k][11:8]}; eb[ebl+3] = fvid[k][7:0];
        ebl += 4;
      end else if (j == furun[k] && !used) begin
        used = 1; err_at = ebl; eb[ebl] = 8'h00; ebl++;
      end else begin
        eb[ebl] = pay[k][j]; ebl++; j++;
      end
    end
    e_pad_at = ebl;
    while (ebl < 60) begin eb[ebl] = 8'h00; ebl++; end
    f = ~ref_crc(ebl);
    exp_len = 0;
    for (int i = 0; i < 15; i++) begin exp_nib[exp_len] = 4'h5; exp_len++; end
    exp_nib[exp_len] = 4'hD; exp_len++;
    for (int i = 0; i < ebl; i++) begin
      exp_nib[exp_len] = eb[i][3:0]; exp_nib[exp_len+1] = eb[i][7:4]; exp_len += 2;
    end
    for (int i = 0; i < 4; i++) begin
      exp_nib[exp_len] = f[8*i +: 4]; exp_nib[exp_len+1] = f[8*i+4 +: 4]; exp_len += 2;
    end
    for (int i = 0; i < exp_len; i++) exp_er[i] = (err_at >= 0) && (i / 2 == err_at + 8);
  endtask

  task automatic cmp_range(int lo, int hi, string req, string what);
    int bad;
    bad = -1;
    for (int i = lo; i <= hi; i++) begin
      if (bad < 0 && (i >= cap_len || cap_nib[i] !== exp_nib[i])) bad = i;
    end
    if (bad < 0) chk(1, req, what, 0, 0);
    else chk(0, req, $sformatf("%s nibble %0d", what, bad),
             (bad < cap_len) ? int'(cap_nib[bad]) : -1, int'(exp_nib[bad]));
  endtask

  task automatic cmp_frame(int k);
    int bad;
    build_exp(k);
    chk(cap_len == exp_len, "R8", $sformatf("frame %0d nibble count", k), cap_len, exp_len);
    cmp_range(0, 15, "R3", $sformatf("frame %0d preamble", k));
    cmp_range(16, 16 + 2 * e_pad_at - 1, "R4", $sformatf("frame %0d body", k));
    if (e_tag_at >= 0) cmp_range(40, 47, "R5", $sformatf("frame %0d tag", k));
    if (e_pad_at < 60) cmp_range(16 + 2 * e_pad_at, 16 + 119, "R6", $sformatf("frame %0d pad", k));
    cmp_range(exp_len - 8, exp_len - 1, "R7", $sformatf("frame %0d crc", k));
    bad = -1;
    for (int i = 0; i < exp_len; i++)
      if (bad < 0 && i < cap_len && cap_er[i] != exp_er[i]) bad = i;
    chk(bad < 0, "R10", $sformatf("frame %0d error marks at %0d", k, bad),
        (bad >= 0) ? int'(cap_er[bad]) : 0, (bad >= 0) ? int'(exp_er[bad]) : 0);
  endtask

  task automatic monitor();
    if (tx_en) begin
      if (!in_frm) begin
        in_frm = 1; cap_len = 0; starts++;
        if (mon_k > 0) chk(gap >= 24, "R9", $sformatf("gap before frame %0d", mon_k), gap, 24);
      end
      if (cap_len < MAXN) begin cap_nib[cap_len] = txd; cap_er[cap_len] = tx_er; end
      cap_len++;
    end else begin
      if (in_frm) begin
        in_frm = 0;
        if (mon_k < NF) cmp_frame(mon_k);
        mon_k++; gap = 0;
      end
      gap++;
    end
  endtask

  task automatic advance();
    ptr++;
    if (ptr == plen[cur_k]) begin
      ptr = 0; skipped = 0; cur_k++;
      if (cur_k == NF) src_active = 0;
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (tick_prev) monitor();
    else if ({txd, tx_en, tx_er} != last_out) hold_bad++;
    last_out = {txd, tx_en, tx_er};
    if (acc_prev) advance();
    case (mon_k % 3)
      0: nib_en = 1'b1;
      1: begin tgl = ~tgl; nib_en = tgl; end
      default: nib_en = ($urandom_range(0, 2) == 0);
    endcase
    if (src_active) begin
      s_valid  = !(ptr == furun[cur_k] && !skipped);
      s_data   = pay[cur_k][ptr];
      s_last   = (ptr == plen[cur_k] - 1);
      tag_en   = ftag[cur_k];
      tag_prio = fprio[cur_k];
      tag_vid  = fvid[cur_k];
    end else begin
      s_valid = 1'b0; s_last = 1'b0;
    end
    #1;
    acc_prev = s_valid && s_ready;
    if (src_active && !s_valid && s_ready) skipped = 1;
    if (s_ready && !nib_en) rdy_bad++;
    tick_prev = nib_en;
  endtask

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd20240917);
    // Directed corner frames, then random ones
    for (int k = 0; k < NF; k++) begin
      ftag[k] = 0; furun[k] = -1;
      fprio[k] = 4'($urandom); fvid[k] = 12'($urandom);
      plen[k] = 14 + $urandom_range(0, 110);
      if (k >= 7) begin
        ftag[k] = bit'($urandom_range(0, 1));
        if ($urandom_range(0, 2) == 0) furun[k] = 14 + $urandom_range(0, plen[k] - 15);
      end
      for (int i = 0; i < MAXP; i++) pay[k][i] = 8'($urandom);
    end
    plen[0] = 14;                                   // heavy padding
    plen[1] = 60;                                   // exactly minimum, no pad
    plen[2] = 56; ftag[2] = 1;                      // tagged, exactly minimum
    plen[3] = 55; ftag[3] = 1;                      // tagged, one pad byte
    plen[4] = 80; furun[4] = 20;                    // underrun
    plen[5] = 100; ftag[5] = 1; furun[5] = 30;      // tagged underrun
    plen[6] = 59;                                   // one pad byte

    rst_n = 0; nib_en = 0; s_valid = 0; s_data = 0; s_last = 0;
    tag_en = 0; tag_prio = 0; tag_vid = 0;
    cur_k = 0; ptr = 0; mon_k = 0; gap = 0; cyc = 0; starts = 0;
    hold_bad = 0; rdy_bad = 0; skipped = 0; src_active = 0;
    acc_prev = 0; tick_prev = 0; in_frm = 0; tgl = 0;
    repeat (4) @(negedge clk);
    nib_en = 1; s_valid = 1;
    #1;
    chk(txd == 4'h0, "R1", "txd in reset", int'(txd), 0);
    chk(tx_en == 1'b0, "R1", "tx_en in reset", int'(tx_en), 0);
    chk(tx_er == 1'b0, "R1", "tx_er in reset", int'(tx_er), 0);
    chk(s_ready == 1'b0, "R1", "s_ready in reset", int'(s_ready), 0);
    @(negedge clk);
    rst_n = 1; nib_en = 0; s_valid = 0;
    #1;
    chk(tx_en == 1'b0 && s_ready == 1'b0, "R1", "idle after reset", int'(tx_en), 0);
    last_out = {txd, tx_en, tx_er};

    // No valid data: nothing may start
    repeat (60) step();
    chk(starts == 0, "R11", "frames started without valid", starts, 0);

    src_active = 1;
    while (mon_k < NF && cyc < 150000) step();
    if (cyc >= 150000) chk(0, "R8", "watchdog expired, frames seen", mon_k, NF);

    repeat (300) step();
    chk(starts == NF, "R11", "frames started in total", starts, NF);
    chk(hold_bad == 0, "R2", "line changes without enable", hold_bad, 0);
    chk(rdy_bad == 0, "R11", "ready without enable", rdy_bad, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule